// File: doc/BRIEF.md
# Credit-based traffic shaper

This block paces a set of transmit queues with a credit-based shaping rule so that a bandwidth-reserved stream never exceeds its share of the link. Each shaped queue owns a signed credit counter. The counter climbs by a programmed idle slope on every cycle in which the queue has a frame waiting but is not sending, and drops by a programmed send slope on every cycle in which the queue is sending. The counter is clamped between an upper and a lower credit bound. A queue may start a frame only while its credit is zero or above.

Software writes slopes in kbit/s and credit bounds in bytes. The block turns these into internal fixed-point step values itself. Slopes are multiplied by 1024 and by a port rate factor that depends on the link speed, then divided by a divider that also depends on the link speed. Credit bounds are multiplied by 8192. Queue 0 is never shaped. Any queue whose shaping enable is low behaves as a plain strict-priority queue: its credit stays at zero and it is eligible whenever it has a frame pending. Arbitration between queues and the moving of frames are handled by neighbouring logic, which reads the eligibility outputs.

Top module: `cbs_shaper`

## Requirements
- R1: Queue 0 is never shaped. Whatever its shaping enable and transmit inputs are, its credit reads 0 and its eligibility equals its pending flag.
- R2: The idle step is `floor(idle_kbps * 1024 * P / D)`, kept to its low 32 bits. P=8 and D=1000000 when `speed_1g`=1; P=4 and D=100000 when `speed_1g`=0.
- R3: The send step uses the same scaling as R2, applied to the send slope magnitude. It is subtracted from the credit.
- R4: Each credit bound equals the signed byte value times 8192, kept to its low 32 bits and read as a signed 32-bit value.
- R5: For a shaped queue that is pending and not transmitting, the next credit is the credit plus the idle step, saturated at the upper bound.
- R6: For a shaped queue that is transmitting, the next credit is the credit minus the send step, saturated at the lower bound. Transmitting takes priority over pending.
- R7: A shaped queue is eligible only when it is pending and its credit is zero or above. The sign is taken from the two's-complement credit output.
- R8: For a shaped queue that is neither pending nor transmitting, a positive credit is cleared to 0 on the next cycle. A negative credit rises by the idle step, but never above 0.
- R9: While a queue's shaping enable is low, its credit becomes 0 on the next cycle and its eligibility equals its pending flag.
- R10: After reset every credit is 0, so each queue's eligibility equals its pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_1g | input | 1 | 1 = gigabit link, 0 = 100 Mb/s link |
| q_pending | input | NQ | Per queue: a frame is waiting |
| q_xmit | input | NQ | Per queue: the queue is sending this cycle |
| shape_en | input | NQ | Per queue: shaping enabled (bit 0 ignored) |
| idle_kbps | input | NQ*32 | Per queue idle slope, kbit/s, unsigned |
| send_kbps | input | NQ*32 | Per queue send slope magnitude, kbit/s, unsigned |
| hi_bytes | input | NQ*32 | Per queue upper credit bound in bytes, signed |
| lo_bytes | input | NQ*32 | Per queue lower credit bound in bytes, signed (negative) |
| tx_eligible | output | NQ | Per queue: allowed to start a frame |
| credit_o | output | NQ*34 | Per queue credit, two's complement |

## Verification
On every cycle, the bound checker checks the direction of each credit move: spending never raises the credit, and growing never lowers it. It also checks that a saturation event lands exactly on the bound, that a positive idle credit is cleared, that a disabled queue returns to zero, that a negative credit is never eligible, and that queue 0 stays unshaped. The exact step sizes produced by the speed-dependent scaling, and the recovery of a negative credit toward zero, can only be shown by the bench's scenarios. Those scenarios run several queues with different slopes at both link speeds and compare each cycle's credit against an independent model.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  localparam int REG_W  = 32;
  localparam int CRED_W = REG_W + 2;
  localparam int PROD_W = 2 * REG_W;

  localparam int unsigned SLOPE_SCALE  = 1024;
  localparam int unsigned BYTE_BITS    = 8;
  localparam int unsigned CREDIT_SCALE = SLOPE_SCALE * BYTE_BITS;
  localparam int unsigned PTR_SLOW     = 4;
  localparam int unsigned PTR_FAST     = 8;
  localparam int unsigned DIV_SLOW     = 100000;
  localparam int unsigned DIV_FAST     = 1000000;

  typedef logic [REG_W-1:0]         reg_t;
  typedef logic signed [CRED_W-1:0] cred_t;
  typedef logic signed [CRED_W:0]   wide_t;

  typedef enum logic [1:0] {
    CA_OFF,
    CA_SPEND,
    CA_GROW,
    CA_REST
  } cred_act_e;

  // kbit/s -> per-cycle fixed-point step
  function automatic reg_t slope_to_step(input reg_t raw, input logic fast);
    logic [PROD_W-1:0] p_fast;
    logic [PROD_W-1:0] p_slow;
    logic [PROD_W-1:0] quo;
    p_fast = PROD_W'(raw) * PROD_W'(SLOPE_SCALE * PTR_FAST);
    p_slow = PROD_W'(raw) * PROD_W'(SLOPE_SCALE * PTR_SLOW);
    if (fast) quo = p_fast / PROD_W'(DIV_FAST);
    else      quo = p_slow / PROD_W'(DIV_SLOW);
    return quo[REG_W-1:0];
  endfunction

  // signed bytes -> signed credit bound (32-bit register image)
  function automatic cred_t bytes_to_bound(input reg_t raw);
    logic [PROD_W-1:0] prod;
    logic signed [REG_W-1:0] img;
    prod = {{REG_W{raw[REG_W-1]}}, raw} * PROD_W'(CREDIT_SCALE);
    img  = $signed(prod[REG_W-1:0]);
    return cred_t'(img);
  endfunction

  function automatic wide_t widen(input cred_t c);
    return {c[CRED_W-1], c};
  endfunction

  function automatic wide_t step_wide(input reg_t s);
    return $signed({{(CRED_W+1-REG_W){1'b0}}, s});
  endfunction

  function automatic wide_t add_step(input cred_t c, input reg_t s);
    return widen(c) + step_wide(s);
  endfunction

  function automatic wide_t sub_step(input cred_t c, input reg_t s);
    return widen(c) - step_wide(s);
  endfunction

endpackage

// File: rtl/cbs_scale.sv
module cbs_scale
  import cbs_pkg::*;
(
  input  logic  speed_fast,
  input  reg_t  idle_raw,
  input  reg_t  send_raw,
  input  reg_t  hi_raw,
  input  reg_t  lo_raw,
  output reg_t  idle_step,
  output reg_t  send_step,
  output cred_t hi_lim,
  output cred_t lo_lim
);

  assign idle_step = slope_to_step(idle_raw, speed_fast);
  assign send_step = slope_to_step(send_raw, speed_fast);
  assign hi_lim    = bytes_to_bound(hi_raw);
  assign lo_lim    = bytes_to_bound(lo_raw);

endmodule

// File: rtl/cbs_credit.sv
module cbs_credit
  import cbs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  shaped,
  input  logic  pending,
  input  logic  xmit,
  input  reg_t  idle_step,
  input  reg_t  send_step,
  input  cred_t hi_lim,
  input  cred_t lo_lim,
  output cred_t credit,
  output logic  ev_sat_hi,
  output logic  ev_sat_lo,
  output logic  ev_clear
);

  cred_act_e act;
  wide_t     up_w;
  wide_t     dn_w;
  cred_t     credit_nx;

  always_comb begin
    if (!shaped)      act = CA_OFF;
    else if (xmit)    act = CA_SPEND;
    else if (pending) act = CA_GROW;
    else              act = CA_REST;
  end

  assign up_w = add_step(credit, idle_step);
  assign dn_w = sub_step(credit, send_step);

  always_comb begin
    credit_nx = credit;
    ev_sat_hi = 1'b0;
    ev_sat_lo = 1'b0;
    ev_clear  = 1'b0;
    unique case (act)
      CA_OFF: credit_nx = '0;
      CA_SPEND: begin
        if (dn_w < widen(lo_lim)) begin
          credit_nx = lo_lim;
          ev_sat_lo = 1'b1;
        end else begin
          credit_nx = dn_w[CRED_W-1:0];
        end
      end
      CA_GROW: begin
        if (up_w > widen(hi_lim)) begin
          credit_nx = hi_lim;
          ev_sat_hi = 1'b1;
        end else begin
          credit_nx = up_w[CRED_W-1:0];
        end
      end
      CA_REST: begin
        if (credit > 0) begin
          credit_nx = '0;
          ev_clear  = 1'b1;
        end else if (up_w > 0) begin
          credit_nx = '0;
        end else begin
          credit_nx = up_w[CRED_W-1:0];
        end
      end
      default: credit_nx = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) credit <= '0;
    else        credit <= credit_nx;
  end

endmodule

// File: rtl/cbs_gate.sv
module cbs_gate
  import cbs_pkg::*;
(
  input  logic  pending,
  input  logic  shaped,
  input  cred_t credit,
  output logic  eligible
);

  logic in_debt;

  assign in_debt  = credit[CRED_W-1];
  assign eligible = pending & (~shaped | ~in_debt);

endmodule

// File: rtl/cbs_shaper.sv
module cbs_shaper
  import cbs_pkg::*;
#(
  parameter int NQ = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         speed_1g,
  input  logic [NQ-1:0]                q_pending,
  input  logic [NQ-1:0]                q_xmit,
  input  logic [NQ-1:0]                shape_en,
  input  logic [NQ-1:0][REG_W-1:0]     idle_kbps,
  input  logic [NQ-1:0][REG_W-1:0]     send_kbps,
  input  logic [NQ-1:0][REG_W-1:0]     hi_bytes,
  input  logic [NQ-1:0][REG_W-1:0]     lo_bytes,
  output logic [NQ-1:0]                tx_eligible,
  output logic [NQ-1:0][CRED_W-1:0]    credit_o
);

  localparam logic [NQ-1:0] SHAPE_OK = {{(NQ-1){1'b1}}, 1'b0};

  logic [NQ-1:0]             shaped;
  logic [NQ-1:0]             ev_sat_hi;
  logic [NQ-1:0]             ev_sat_lo;
  logic [NQ-1:0]             ev_clear;
  logic [NQ-1:0][CRED_W-1:0] hi_lim_a;
  logic [NQ-1:0][CRED_W-1:0] lo_lim_a;

  assign shaped = shape_en & SHAPE_OK;

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    reg_t  idle_step;
    reg_t  send_step;
    cred_t hi_lim;
    cred_t lo_lim;
    cred_t credit;
    logic  elig;

    cbs_scale u_scale (
      .speed_fast (speed_1g),
      .idle_raw   (idle_kbps[q]),
      .send_raw   (send_kbps[q]),
      .hi_raw     (hi_bytes[q]),
      .lo_raw     (lo_bytes[q]),
      .idle_step  (idle_step),
      .send_step  (send_step),
      .hi_lim     (hi_lim),
      .lo_lim     (lo_lim)
    );

    cbs_credit u_credit (
      .clk       (clk),
      .rst_n     (rst_n),
      .shaped    (shaped[q]),
      .pending   (q_pending[q]),
      .xmit      (q_xmit[q]),
      .idle_step (idle_step),
      .send_step (send_step),
      .hi_lim    (hi_lim),
      .lo_lim    (lo_lim),
      .credit    (credit),
      .ev_sat_hi (ev_sat_hi[q]),
      .ev_sat_lo (ev_sat_lo[q]),
      .ev_clear  (ev_clear[q])
    );

    cbs_gate u_gate (
      .pending  (q_pending[q]),
      .shaped   (shaped[q]),
      .credit   (credit),
      .eligible (elig)
    );

    assign hi_lim_a[q]    = hi_lim;
    assign lo_lim_a[q]    = lo_lim;
    assign credit_o[q]    = credit;
    assign tx_eligible[q] = elig;
  end

endmodule

// File: rtl/cbs_shaper_chk.sv
module cbs_shaper_chk
  import cbs_pkg::*;
#(
  parameter int NQ = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NQ-1:0]             q_pending,
  input logic [NQ-1:0]             q_xmit,
  input logic [NQ-1:0]             shape_en,
  input logic [NQ-1:0]             tx_eligible,
  input logic [NQ-1:0][CRED_W-1:0] credit_o,
  input logic [NQ-1:0][CRED_W-1:0] hi_lim_a,
  input logic [NQ-1:0][CRED_W-1:0] lo_lim_a,
  input logic [NQ-1:0]             ev_sat_hi,
  input logic [NQ-1:0]             ev_sat_lo,
  input logic [NQ-1:0]             ev_clear
);

  p_q0_unshaped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_o[0] == '0) && (tx_eligible[0] == q_pending[0]));

  for (genvar q = 1; q < NQ; q++) begin : g_chk
    p_grow_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (shape_en[q] && q_pending[q] && !q_xmit[q]) |=>
        ($signed(credit_o[q]) >= $signed($past(credit_o[q]))));

    p_spend_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (shape_en[q] && q_xmit[q]) |=>
        ($signed(credit_o[q]) <= $signed($past(credit_o[q]))));

    p_sat_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_sat_hi[q] |=> (credit_o[q] == $past(hi_lim_a[q])));

    p_sat_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_sat_lo[q] |=> (credit_o[q] == $past(lo_lim_a[q])));

    p_debt_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (shape_en[q] && $signed(credit_o[q]) < 0) |-> !tx_eligible[q]);

    p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (shape_en[q] && !q_pending[q] && !q_xmit[q] && $signed(credit_o[q]) > 0)
        |=> (credit_o[q] == '0));

    p_rest_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (shape_en[q] && !q_pending[q] && !q_xmit[q]) |=> ($signed(credit_o[q]) <= 0));

    p_off_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !shape_en[q] |=> (credit_o[q] == '0));

    p_one_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_sat_hi[q], ev_sat_lo[q], ev_clear[q]}));
  end

endmodule

bind cbs_shaper cbs_shaper_chk #(.NQ(NQ)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .q_pending   (q_pending),
  .q_xmit      (q_xmit),
  .shape_en    (shape_en),
  .tx_eligible (tx_eligible),
  .credit_o    (credit_o),
  .hi_lim_a    (hi_lim_a),
  .lo_lim_a    (lo_lim_a),
  .ev_sat_hi   (ev_sat_hi),
  .ev_sat_lo   (ev_sat_lo),
  .ev_clear    (ev_clear)
);

// File: tb/cbs_shaper_tb_top.sv
module cbs_shaper_tb_top;

  localparam int NQ = 4;
  localparam int RW = 32;
  localparam int CW = 34;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   speed_1g = 1'b1;
  logic [NQ-1:0]          q_pending = '0;
  logic [NQ-1:0]          q_xmit = '0;
  logic [NQ-1:0]          shape_en = '0;
  logic [NQ-1:0][RW-1:0]  idle_kbps;
  logic [NQ-1:0][RW-1:0]  send_kbps;
  logic [NQ-1:0][RW-1:0]  hi_bytes;
  logic [NQ-1:0][RW-1:0]  lo_bytes;
  logic [NQ-1:0]          tx_eligible;
  logic [NQ-1:0][CW-1:0]  credit_o;

  always #10 clk = ~clk;

  cbs_shaper #(.NQ(NQ)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .speed_1g    (speed_1g),
    .q_pending   (q_pending),
    .q_xmit      (q_xmit),
    .shape_en    (shape_en),
    .idle_kbps   (idle_kbps),
    .send_kbps   (send_kbps),
    .hi_bytes    (hi_bytes),
    .lo_bytes    (lo_bytes),
    .tx_eligible (tx_eligible),
    .credit_o    (credit_o)
  );

  typedef struct {
    int     q;
    longint cred;
    bit     elig;
    string  tag;
  } exp_t;

  exp_t   sbq[$];
  longint mcred[NQ];
  int     n_checks = 0;
  int     n_errors = 0;
  bit     done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // speed-dependent slope scaling, written from the requirement
  function automatic longint step_of(input logic [RW-1:0] raw, input bit fast);
    longint r;
    longint mul;
    longint dv;
    r   = longint'({32'b0, raw});
    mul = fast ? 64'd8192 : 64'd4096;
    dv  = fast ? 64'd1000000 : 64'd100000;
    return ((r * mul) / dv) & 64'hFFFF_FFFF;
  endfunction

  function automatic longint bound_of(input logic [RW-1:0] raw);
    longint b;
    longint v;
    b = longint'($signed(raw));
    v = (b * 8192) & 64'hFFFF_FFFF;
    if (v >= 64'h8000_0000) v = v - 64'h1_0000_0000;
    return v;
  endfunction

  // one cycle of stimulus; every queue gets an expected item
  task automatic run(input int tq, input bit p, input bit x, input bit e,
                     input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      q_pending = '0;
      q_xmit    = '0;
      shape_en  = '0;
      q_pending[tq] = p;
      q_xmit[tq]    = x;
      shape_en[tq]  = e;
      for (int k = 0; k < NQ; k++) begin
        bit     kp;
        bit     kx;
        bit     ke;
        longint c;
        longint nx;
        longint id;
        longint sd;
        longint hi;
        longint lo;
        exp_t   it;
        kp = q_pending[k];
        kx = q_xmit[k];
        ke = shape_en[k];
        c  = mcred[k];
        id = step_of(idle_kbps[k], speed_1g);
        sd = step_of(send_kbps[k], speed_1g);
        hi = bound_of(hi_bytes[k]);
        lo = bound_of(lo_bytes[k]);
        if (k == 0 || !ke) nx = 0;
        else if (kx) begin
          nx = c - sd;
          if (nx < lo) nx = lo;
        end else if (kp) begin
          nx = c + id;
          if (nx > hi) nx = hi;
        end else if (c > 0) nx = 0;
        else begin
          nx = c + id;
          if (nx > 0) nx = 0;
        end
        mcred[k] = nx;
        it.q    = k;
        it.cred = nx;
        it.elig = kp && (k == 0 || !ke || nx >= 0);
        it.tag  = (k == 0) ? "R1" : ((k == tq) ? tag : "R9");
        sbq.push_back(it);
      end
    end
  endtask

  // monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sbq.size() > 0) begin
        exp_t   it;
        longint act;
        it  = sbq.pop_front();
        act = longint'($signed(credit_o[it.q]));
        check(act == it.cred, $sformatf("%s q%0d credit", it.tag, it.q), act, it.cred);
        check(tx_eligible[it.q] == it.elig, $sformatf("%s q%0d eligible", it.tag, it.q),
              longint'(tx_eligible[it.q]), longint'(it.elig));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    idle_kbps[0] = 32'd300000; send_kbps[0] = 32'd700000;
    hi_bytes[0]  = 32'd5;      lo_bytes[0]  = -32'sd5;
    idle_kbps[1] = 32'd100000; send_kbps[1] = 32'd900000;
    hi_bytes[1]  = 32'd2;      lo_bytes[1]  = -32'sd3;
    idle_kbps[2] = 32'd250000; send_kbps[2] = 32'd750000;
    hi_bytes[2]  = 32'd1;      lo_bytes[2]  = -32'sd1;
    idle_kbps[3] = 32'd50000;  send_kbps[3] = 32'd950000;
    hi_bytes[3]  = 32'd4;      lo_bytes[3]  = -32'sd2;
    for (int k = 0; k < NQ; k++) mcred[k] = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    for (int k = 0; k < NQ; k++) begin
      check(credit_o[k] == '0, "R10 credit after reset", longint'($signed(credit_o[k])), 0);
      check(tx_eligible[k] == 1'b0, "R10 eligible after reset", longint'(tx_eligible[k]), 0);
    end

    // R2/R5: grow to the upper bound at gigabit speed (819 per cycle, cap 16384)
    run(1, 1, 0, 1, 22, "R2/R5");
    // R3/R6: spend into debt and hit the lower bound
    run(1, 0, 1, 1, 6, "R3/R6");
    // R6: transmit wins over pending
    run(1, 1, 1, 1, 2, "R6");
    // R7: pending in debt is blocked until credit recovers
    run(1, 1, 0, 1, 35, "R7");
    // R8: go into debt, then rest: rises toward zero but not above
    run(1, 0, 1, 1, 3, "R8");
    run(1, 0, 0, 1, 14, "R8");
    // R8: positive credit at rest is cleared
    run(1, 1, 0, 1, 5, "R5");
    run(1, 0, 0, 1, 2, "R8");
    // R9: disable in debt, pending stays eligible
    run(1, 0, 1, 1, 2, "R6");
    run(1, 1, 0, 0, 3, "R9");
    // R1: queue 0 with enable and transmit set
    run(0, 1, 1, 1, 3, "R1");
    run(0, 1, 0, 1, 2, "R1");
    // R4: larger upper bound on queue 3 (409 per cycle, cap 32768)
    run(3, 1, 0, 1, 85, "R4");
    run(3, 0, 1, 1, 12, "R4");
    // R2/R3: 100 Mb/s scaling on queue 2
    @(negedge clk);
    speed_1g = 1'b0;
    run(2, 1, 0, 1, 4, "R2");
    run(2, 0, 1, 1, 4, "R3");
    run(2, 1, 0, 1, 6, "R7");
    run(2, 0, 0, 1, 3, "R8");

    @(negedge clk);
    q_pending = '0; q_xmit = '0; shape_en = '0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule